// File: doc/BRIEF.md
# I2C Serial Memory Slave with Persistent Address Counter

This block is the slave side of a two-wire serial memory. It oversamples SCL and SDA with the system clock, recognises START, repeated START and STOP, and compares the device byte against a fixed identifier. It holds a byte-addressed array of 2048 entries and one address counter that every access moves forward. A write-type transfer loads that counter from three block bits in the device byte and an 8-bit word address. Any further bytes in that transfer are stored at the counter. A read-type transfer returns bytes starting at the counter. The master can read from wherever the last access stopped, or it can send a word address and then a repeated START (a dummy write) to read from a chosen location. It can also keep acknowledging to stream the array, and the counter wraps from the top address to zero.

The bus pins are open drain. The block reports only an output enable, and a high enable means "pull SDA low". A separate preload port writes array bytes directly from the system side without touching the counter.

The bit-level controller uses the states IDLE, DEV (device byte in), DEV_ACK, WADR (word address in), WADR_ACK, WDAT (write data in), WDAT_ACK, RDAT (data byte out), RACK (waiting for the master's acknowledge) and SKIP (ignoring the bus). Its transitions are as follows:
- START goes to DEV from any state, and STOP goes to IDLE from any state.
- From DEV, the end of the byte goes to DEV_ACK on a match and to SKIP otherwise.
- DEV_ACK goes to RDAT for a read and to WADR for a write.
- WADR goes to WADR_ACK.
- WADR_ACK and WDAT_ACK go to WDAT.
- WDAT goes to WDAT_ACK.
- RDAT goes to RACK after eight bits.
- RACK goes back to RDAT on an acknowledge and to SKIP on a missing acknowledge.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: After reset SDA is released (sda_oe low) and the address counter is 0, so the first immediate read returns the byte at address 0.
- R2: The slave acknowledges (drives SDA low during the ninth SCL clock) only when bits 7:4 of the device byte equal 4'b1010. Otherwise it does not acknowledge, and it leaves SDA released until the next START.
- R3: A device byte with bit 0 = 0, followed by a word address byte, loads the counter with {device bits 3:1, word address} and both bytes are acknowledged. After a repeated START and a device byte with bit 0 = 1, the byte at that address is returned.
- R4: A device byte with bit 0 = 1 returns the byte at the counter. After any read or write at address N, the counter is N+1.
- R5: Each master acknowledge after a data byte makes the slave send the byte at the next address.
- R6: After address 2047 the counter wraps to 0, and streaming continues without a gap.
- R7: When the master does not acknowledge a data byte, the slave releases SDA and sends nothing more until the next START.
- R8: Data bytes are sent MSB first, and SDA output changes only while SCL is low.
- R9: Bytes that follow the word address in a write transfer are acknowledged, stored at the counter, and each one advances the counter.
- R10: A START at any point abandons the partial byte and restarts device-byte reception. A partial data byte is not stored, and the loaded counter is kept.
- R11: The preload port writes a byte into the array without changing the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 11 | Preload byte address |
| pre_data | input | 8 | Preload byte value |

## Verification
The assertions rely on several properties of the bus:
- Each SCL phase lasts several system clocks, longer than the three-flop synchronizer delay.
- The master moves SDA only while SCL is low, except when it forms START or STOP.
- The master never issues START or STOP while the slave is pulling SDA low.

The stimulus keeps to these rules. It holds each SCL half period at twenty system clocks and changes SDA five clocks after each falling edge. It issues repeated STARTs only after the slave has released the line. A bus monitor counts any SDA-enable change that occurs while SCL stays high.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADR,
        S_WADR_ACK,
        S_WDAT,
        S_WDAT_ACK,
        S_RDAT,
        S_RACK,
        S_SKIP
    } bus_state_e;

    localparam logic [3:0] DEV_ID = 4'b1010;

endpackage

// File: rtl/i2cr_pin_sync.sv
module i2cr_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);

    logic [2:0] scl_sh;
    logic [2:0] sda_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= 3'b111;
            sda_sh <= 3'b111;
        end else begin
            scl_sh <= {scl_sh[1:0], scl_pin};
            sda_sh <= {sda_sh[1:0], sda_pin};
        end
    end

    // index 1 is the synchronized level, index 2 the previous one
    assign scl_lvl  = scl_sh[1];
    assign sda_lvl  = sda_sh[1];
    assign scl_rise = scl_sh[1] && !scl_sh[2];
    assign scl_fall = !scl_sh[1] && scl_sh[2];
    assign start_c  = scl_sh[1] && scl_sh[2] && sda_sh[2] && !sda_sh[1];
    assign stop_c   = scl_sh[1] && scl_sh[2] && !sda_sh[2] && sda_sh[1];

endmodule

// File: rtl/i2cr_array.sv
module i2cr_array #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
    import i2cr_pkg::*;
#(
    parameter int AW = 11,
    localparam int BLK_W = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_c,
    input  logic          stop_c,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);

    bus_state_e state, state_n;

    logic [2:0]       bit_cnt;
    logic [7:0]       shreg;
    logic             byte_full;
    logic             ninth;
    logic             rw_q;
    logic [BLK_W-1:0] blk_q;
    logic [AW-1:0]    cnt;

    logic evt_none, rx_state, ack_state;
    logic byte_end, ack_end, id_ok;
    logic load_rd, wr_fire, adr_load, cnt_step;

    assign evt_none  = !start_c && !stop_c;
    assign rx_state  = (state == S_DEV) || (state == S_WADR) || (state == S_WDAT);
    assign ack_state = (state == S_DEV_ACK) || (state == S_WADR_ACK) || (state == S_WDAT_ACK);
    assign byte_end  = rx_state && scl_fall && byte_full && evt_none;
    assign ack_end   = ack_state && scl_fall && ninth && evt_none;
    assign id_ok     = (shreg[7:4] == DEV_ID);
    assign load_rd   = evt_none && scl_fall && ninth &&
                       (((state == S_DEV_ACK) && rw_q) || (state == S_RACK));
    assign wr_fire   = byte_end && (state == S_WDAT);
    assign adr_load  = byte_end && (state == S_WADR);
    assign cnt_step  = load_rd || wr_fire;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next-state selection
    always_comb begin
        state_n = state;
        if (start_c) begin
            state_n = S_DEV;
        end else if (stop_c) begin
            state_n = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE, S_SKIP: state_n = state;
                S_DEV: begin
                    if (byte_end) state_n = id_ok ? S_DEV_ACK : S_SKIP;
                end
                S_WADR: begin
                    if (byte_end) state_n = S_WADR_ACK;
                end
                S_WDAT: begin
                    if (byte_end) state_n = S_WDAT_ACK;
                end
                S_DEV_ACK: begin
                    if (ack_end) state_n = rw_q ? S_RDAT : S_WADR;
                end
                S_WADR_ACK, S_WDAT_ACK: begin
                    if (ack_end) state_n = S_WDAT;
                end
                S_RDAT: begin
                    if (scl_fall && (bit_cnt == 3'd7)) state_n = S_RACK;
                end
                S_RACK: begin
                    if (scl_rise && sda_lvl) state_n = S_SKIP;
                    else if (load_rd) state_n = S_RDAT;
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // datapath: shifter, bit counter, phase flags, address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= 3'd0;
            shreg     <= 8'd0;
            byte_full <= 1'b0;
            ninth     <= 1'b0;
            rw_q      <= 1'b0;
            blk_q     <= '0;
            cnt       <= '0;
        end else begin
            if (!evt_none) begin
                bit_cnt   <= 3'd0;
                byte_full <= 1'b0;
                ninth     <= 1'b0;
            end else begin
                if (rx_state && scl_rise) begin
                    shreg   <= {shreg[6:0], sda_lvl};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) byte_full <= 1'b1;
                end
                if (byte_end) begin
                    byte_full <= 1'b0;
                    bit_cnt   <= 3'd0;
                    if (state == S_DEV) begin
                        rw_q  <= shreg[0];
                        blk_q <= shreg[BLK_W:1];
                    end
                end
                if (ack_state && scl_rise) ninth <= 1'b1;
                if ((state == S_RACK) && scl_rise) ninth <= !sda_lvl;
                if (ack_end || load_rd) begin
                    ninth   <= 1'b0;
                    bit_cnt <= 3'd0;
                end
                if (load_rd) begin
                    shreg <= rd_data;
                end else if ((state == S_RDAT) && scl_fall) begin
                    shreg   <= {shreg[6:0], 1'b0};
                    bit_cnt <= bit_cnt + 3'd1;
                end
            end
            if (adr_load) begin
                cnt <= {blk_q, shreg};
            end else if (cnt_step) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            S_DEV_ACK, S_WADR_ACK, S_WDAT_ACK: sda_oe = 1'b1;
            S_RDAT:                            sda_oe = !shreg[7];
            default:                           sda_oe = 1'b0;
        endcase
    end

    assign mem_addr = cnt;
    assign wr_en    = wr_fire;
    assign wr_data  = shreg;

    // R8: the slave never moves SDA while SCL stays high
    a_r8_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_c) && !$past(stop_c))
        |-> $stable(sda_oe));

    // R5: every counter step adds exactly one
    a_r5_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_step |=> (cnt == AW'($past(cnt) + 1'b1)));

    // R6: stepping from the top address lands on zero
    a_r6_counter_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step && (cnt == '1)) |=> (cnt == '0));

    // R7: a missing master acknowledge releases the line and silences the slave
    a_r7_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_RACK) && scl_rise && sda_lvl && evt_none)
        |=> (!sda_oe && (state == S_SKIP)));

    // R10: a START always restarts device-byte reception with SDA released
    a_r10_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> ((state == S_DEV) && !sda_oe));

    // R2: while ignoring the bus the slave never pulls SDA
    a_r2_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP) |-> !sda_oe);

endmodule

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [7:0]    pre_data
);

    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
    logic [AW-1:0] eng_addr;
    logic          eng_we;
    logic [7:0]    eng_wdata;
    logic [7:0]    rd_data;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [7:0]    arr_wdata;

    i2cr_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_pin  (scl_i),
        .sda_pin  (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    i2cr_engine #(.AW(AW)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c),
        .rd_data  (rd_data),
        .mem_addr (eng_addr),
        .wr_en    (eng_we),
        .wr_data  (eng_wdata),
        .sda_oe   (sda_oe)
    );

    // preload has priority over a bus write in the same cycle
    assign arr_we    = pre_we || eng_we;
    assign arr_waddr = pre_we ? pre_addr : eng_addr;
    assign arr_wdata = pre_we ? pre_data : eng_wdata;

    i2cr_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (eng_addr),
        .rdata (rd_data)
    );

endmodule

// File: tb/i2c_eeprom_reader_bench.sv
module i2c_eeprom_reader_bench;

    localparam int HALF = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        pre_we = 1'b0;
    logic [10:0] pre_addr = '0;
    logic [7:0]  pre_data = '0;
    wire         sda_bus = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    int viol = 0;
    bit done = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;
    logic [7:0] bm [2048];

    always #2.5 clk = ~clk;

    i2c_eeprom_reader u_i2c_eeprom_reader (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
    );

    function automatic logic [7:0] pat(input logic [10:0] a);
        return a[7:0] ^ {a[10:8], a[10:8], a[10:9]} ^ 8'h5A;
    endfunction

    // R8 bus monitor: SDA enable must hold while SCL stays high
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe !== oe_prev)) viol++;
        scl_prev <= scl_m;
        oe_prev  <= sda_oe;
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        repeat (5) @(negedge clk);
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        repeat (5) @(negedge clk);
        sda_m = b;
        repeat (HALF - 5) @(negedge clk);
        scl_m = 1'b1;
        repeat (HALF / 2) @(negedge clk);
        s = sda_bus;
        repeat (HALF / 2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(!mack, s);
    endtask

    task automatic preload(input logic [10:0] a, input logic [7:0] v);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = v;
        @(negedge clk);
        pre_we = 1'b0;
        bm[a] = v;
    endtask

    task automatic set_addr(input logic [10:0] a);
        logic ak;
        bus_start();
        send_byte({4'b1010, a[10:8], 1'b0}, ak);
        chk("R3 device write ack", ak, 1);
        send_byte(a[7:0], ak);
        chk("R3 word address ack", ak, 1);
    endtask

    task automatic read_open();
        logic ak;
        bus_start();
        send_byte(8'hA1, ak);
        chk("R2 read device ack", ak, 1);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 sda released after reset", sda_oe, 0);
        read_open();
        recv_byte(1'b0, d);
        chk("R1 first immediate read at 0", d, bm[0]);
        bus_stop();
    endtask

    task automatic t_immediate(input logic [10:0] exp_a);
        logic [7:0] d;
        read_open();
        recv_byte(1'b0, d);
        chk("R4 immediate read at last+1", d, bm[exp_a]);
        bus_stop();
    endtask

    task automatic t_bad_id();
        logic ak;
        logic [7:0] d;
        bus_start();
        send_byte(8'hB1, ak);
        chk("R2 foreign id not acked", ak, 0);
        recv_byte(1'b0, d);
        chk("R2 bus ignored after mismatch", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_selective();
        logic [7:0] d;
        set_addr(11'h345);
        read_open();
        recv_byte(1'b0, d);
        chk("R3 selective read byte", d, bm[11'h345]);
        recv_byte(1'b0, d);
        chk("R7 silent after master nack", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_seq_wrap();
        logic [7:0] d;
        set_addr(11'h7FE);
        read_open();
        recv_byte(1'b1, d);
        chk("R5 stream byte 0", d, bm[11'h7FE]);
        recv_byte(1'b1, d);
        chk("R5 stream top address", d, bm[11'h7FF]);
        recv_byte(1'b1, d);
        chk("R6 wrap to address 0", d, bm[11'h000]);
        recv_byte(1'b0, d);
        chk("R5 stream after wrap", d, bm[11'h001]);
        bus_stop();
        t_immediate(11'h002);
    endtask

    task automatic t_write();
        logic ak;
        logic [7:0] d;
        set_addr(11'h110);
        send_byte(8'hC3, ak);
        chk("R9 first data acked", ak, 1);
        send_byte(8'h3C, ak);
        chk("R9 second data acked", ak, 1);
        bus_stop();
        bm[11'h110] = 8'hC3;
        bm[11'h111] = 8'h3C;
        set_addr(11'h110);
        read_open();
        recv_byte(1'b1, d);
        chk("R9 stored first byte", d, 8'hC3);
        recv_byte(1'b0, d);
        chk("R9 stored second byte", d, 8'h3C);
        bus_stop();
        t_immediate(11'h112);
    endtask

    task automatic t_abort();
        logic s;
        logic [7:0] d;
        set_addr(11'h220);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        read_open();
        recv_byte(1'b0, d);
        chk("R10 counter kept, partial byte unstored", d, bm[11'h220]);
        bus_stop();
        bus_start();
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        read_open();
        recv_byte(1'b0, d);
        chk("R10 restart inside device byte", d, bm[11'h221]);
        bus_stop();
    endtask

    task automatic t_preload();
        logic [7:0] d;
        set_addr(11'h600);
        bus_stop();
        preload(11'h055, 8'h99);
        t_immediate(11'h600);
        set_addr(11'h055);
        read_open();
        recv_byte(1'b0, d);
        chk("R11 preloaded byte visible", d, 8'h99);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 2048; a++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_addr = 11'(a); pre_data = pat(11'(a));
            bm[a] = pat(11'(a));
        end
        @(negedge clk);
        pre_we = 1'b0;
        hp();
        t_reset();
        t_immediate(11'h001);
        t_bad_id();
        t_selective();
        t_seq_wrap();
        t_write();
        t_abort();
        t_preload();
        chk("R8 sda steady while scl high", viol, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule